// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A request carries a 32-bit virtual address, a read/write flag, a user/supervisor flag and the base address of the top-level table. The walker fetches the top-level entry and, unless that entry maps a 4 MB page directly, it then fetches the second-level entry. It checks presence and permission at each level and sets the accessed and dirty flags in the entries it uses. It then returns either a physical address or a fault record.

The walker reaches memory through a single request/acknowledge port. A request stays asserted with stable address, direction and data until the memory returns a one-cycle acknowledge, and read data arrives with that acknowledge. The walker accepts one walk at a time and reports each walk with one result pulse. The fault record carries the faulting address, the cause (entry not present, or permission violation), the access direction and the privilege mode.

Entry layout, shared by both levels: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty (leaf entries only), bit 7 large page (top level only), bits 31:12 frame base.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, and mem_req and done_valid are 0.
- R2: The first read goes to dir_base + 4·VA[31:22]. The second-level read goes to {top-entry[31:12], VA[21:12], 2'b00}.
- R3: For a 4 KB mapping the result address is {leaf-entry[31:12], VA[11:0]}.
- R4: A top-level entry with bit 7 set is a leaf. The result is {entry[31:22], VA[21:0]}, and no second-level read takes place.
- R5: An entry with bit 0 clear ends the walk with a fault, flt_not_present=1, and no further memory access. At the top level this means both levels are missing.
- R6: A user access to an entry with bit 2 clear, or a write to an entry with bit 1 clear, at either level, faults with flt_not_present=0. An entry that is absent is reported as not present even if its permissions would also fail.
- R7: On a fault, flt_vaddr, flt_write and flt_user equal the request's address, direction and mode.
- R8: An entry that passes its checks and has bit 5 clear is written back with bit 5 set. A top-level writeback comes before the second-level read.
- R9: A leaf entry used for a write with bit 6 clear is written back with bit 6 set. A non-leaf top-level entry never gets bit 6 set.
- R10: No writeback takes place when no flag changes, and no entry that failed a check is written.
- R11: req_ready is 1 only while idle. req_valid during a walk is ignored and does not change that walk's result.
- R12: While mem_req is 1 and mem_ack is 0, mem_req stays 1 in the next cycle, and mem_addr, mem_we and mem_wdata stay unchanged.
- R13: Each accepted request produces exactly one single-cycle done_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| dir_base | input | 32 | Physical base of top-level table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access to memory |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Write data (entry with updated flags) |
| mem_ack | input | 1 | One-cycle completion of the access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done_valid | output | 1 | Single-cycle result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_paddr | output | 32 | Translated physical address |
| flt_vaddr | output | 32 | Faulting virtual address |
| flt_not_present | output | 1 | 1 = absent entry, 0 = permission violation |
| flt_write | output | 1 | Faulting access was a write |
| flt_user | output | 1 | Faulting access was in user mode |

## Verification
The hardest situation to reach is a walk that writes the top-level entry back and then faults at the second level. In that case one write must appear and the following entry must stay untouched. The stimulus prepares table contents in a sparse memory model before each walk. It pairs entries whose accessed flag is clear with second-level entries that are absent or lack permission. The bench varies the acknowledge latency from zero to three cycles so that the hold rule is exercised on both reads and writebacks. A request with conflicting fields is held high through a whole walk to show that it is ignored.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int unsigned AW      = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned LEVELS  = 2;

    localparam int unsigned BIT_P   = 0;
    localparam int unsigned BIT_RW  = 1;
    localparam int unsigned BIT_US  = 2;
    localparam int unsigned BIT_A   = 5;
    localparam int unsigned BIT_D   = 6;
    localparam int unsigned BIT_PS  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_CHK_DIR,
        ST_RD_TBL,
        ST_CHK_TBL,
        ST_WB,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        walk_st_e        st;
        logic [AW-1:0]   va;
        logic            wr;
        logic            usr;
        logic [AW-1:0]   base;
        logic [AW-1:0]   dir_ent;
        logic [AW-1:0]   tbl_ent;
        logic [AW-1:0]   wb_addr;
        logic [AW-1:0]   wb_data;
        logic            wb_last;
        logic [AW-1:0]   pa;
        logic            np;
    } walk_regs_t;
endpackage

// File: rtl/pw_addr_calc.sv
module pw_addr_calc #(
    parameter int unsigned AW    = pw_pkg::AW,
    parameter int unsigned OFF_W = pw_pkg::OFF_W,
    parameter int unsigned IDX_W = pw_pkg::IDX_W
) (
    input  logic [AW-1:0]       va,
    input  logic [AW-1:0]       base,
    input  logic [AW-OFF_W-1:0] dir_frame,
    input  logic [AW-OFF_W-1:0] tbl_frame,
    output logic [AW-1:0]       dir_addr,
    output logic [AW-1:0]       tbl_addr,
    output logic [AW-1:0]       pa_small,
    output logic [AW-1:0]       pa_large
);
    localparam int unsigned LARGE_W = OFF_W + IDX_W;
    localparam int unsigned PAD_W   = AW - IDX_W - 2;
    localparam int unsigned HI_W    = AW - LARGE_W;

    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] mid_idx;

    always_comb begin
        top_idx  = va[AW-1 -: IDX_W];
        mid_idx  = va[OFF_W +: IDX_W];
        dir_addr = base + {{PAD_W{1'b0}}, top_idx, 2'b00};
        tbl_addr = {dir_frame, mid_idx, 2'b00};
        pa_small = {tbl_frame, va[OFF_W-1:0]};
        pa_large = {dir_frame[AW-OFF_W-1 -: HI_W], va[LARGE_W-1:0]};
    end
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check #(
    parameter int unsigned AW = pw_pkg::AW
) (
    input  logic [AW-1:0] ent,
    input  logic          is_write,
    input  logic          is_user,
    input  logic          is_leaf,
    output logic          present,
    output logic          allowed,
    output logic [AW-1:0] upd,
    output logic          wb_need
);
    import pw_pkg::*;

    always_comb begin
        present = ent[BIT_P];
        allowed = !((is_user && !ent[BIT_US]) || (is_write && !ent[BIT_RW]));
        upd = ent;
        upd[BIT_A] = 1'b1;
        if (is_leaf && is_write) begin
            upd[BIT_D] = 1'b1;
        end
        wb_need = (upd != ent);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [31:0] dir_base,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done_valid,
    output logic        done_fault,
    output logic [31:0] done_paddr,
    output logic [31:0] flt_vaddr,
    output logic        flt_not_present,
    output logic        flt_write,
    output logic        flt_user
);
    import pw_pkg::*;

    walk_regs_t q, d;

    logic [AW-1:0] dir_addr, tbl_addr, pa_small, pa_large;

    logic [LEVELS-1:0] lvl_present, lvl_allowed, lvl_wb, lvl_leaf;
    logic [AW-1:0]     lvl_ent [LEVELS];
    logic [AW-1:0]     lvl_upd [LEVELS];

    pw_addr_calc #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
        .va        (q.va),
        .base      (q.base),
        .dir_frame (q.dir_ent[AW-1:OFF_W]),
        .tbl_frame (q.tbl_ent[AW-1:OFF_W]),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr),
        .pa_small  (pa_small),
        .pa_large  (pa_large)
    );

    always_comb begin
        lvl_ent[0]  = q.dir_ent;
        lvl_ent[1]  = q.tbl_ent;
        lvl_leaf[0] = q.dir_ent[BIT_PS];
        lvl_leaf[1] = 1'b1;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pw_entry_check #(.AW(AW)) u_chk (
            .ent      (lvl_ent[g]),
            .is_write (q.wr),
            .is_user  (q.usr),
            .is_leaf  (lvl_leaf[g]),
            .present  (lvl_present[g]),
            .allowed  (lvl_allowed[g]),
            .upd      (lvl_upd[g]),
            .wb_need  (lvl_wb[g])
        );
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_RD_DIR;
                    d.va   = req_vaddr;
                    d.wr   = req_write;
                    d.usr  = req_user;
                    d.base = dir_base;
                    d.np   = 1'b0;
                end
            end
            ST_RD_DIR: begin
                if (mem_ack) begin
                    d.dir_ent = mem_rdata;
                    d.st      = ST_CHK_DIR;
                end
            end
            ST_CHK_DIR: begin
                if (!lvl_present[0]) begin
                    d.np = 1'b1;
                    d.st = ST_FAULT;
                end else if (!lvl_allowed[0]) begin
                    d.np = 1'b0;
                    d.st = ST_FAULT;
                end else begin
                    d.pa      = pa_large;
                    d.wb_addr = dir_addr;
                    d.wb_data = lvl_upd[0];
                    d.wb_last = lvl_leaf[0];
                    if (lvl_wb[0]) begin
                        d.st = ST_WB;
                    end else if (lvl_leaf[0]) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st = ST_RD_TBL;
                    end
                end
            end
            ST_RD_TBL: begin
                if (mem_ack) begin
                    d.tbl_ent = mem_rdata;
                    d.st      = ST_CHK_TBL;
                end
            end
            ST_CHK_TBL: begin
                if (!lvl_present[1]) begin
                    d.np = 1'b1;
                    d.st = ST_FAULT;
                end else if (!lvl_allowed[1]) begin
                    d.np = 1'b0;
                    d.st = ST_FAULT;
                end else begin
                    d.pa      = pa_small;
                    d.wb_addr = tbl_addr;
                    d.wb_data = lvl_upd[1];
                    d.wb_last = 1'b1;
                    d.st      = lvl_wb[1] ? ST_WB : ST_DONE;
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    d.st = q.wb_last ? ST_DONE : ST_RD_TBL;
                end
            end
            ST_DONE:  d.st = ST_IDLE;
            ST_FAULT: d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready = (q.st == ST_IDLE);
        mem_req   = (q.st == ST_RD_DIR) || (q.st == ST_RD_TBL) || (q.st == ST_WB);
        mem_we    = (q.st == ST_WB);
        unique case (q.st)
            ST_RD_DIR: mem_addr = dir_addr;
            ST_RD_TBL: mem_addr = tbl_addr;
            ST_WB:     mem_addr = q.wb_addr;
            default:   mem_addr = '0;
        endcase
        mem_wdata       = (q.st == ST_WB) ? q.wb_data : '0;
        done_valid      = (q.st == ST_DONE) || (q.st == ST_FAULT);
        done_fault      = (q.st == ST_FAULT);
        done_paddr      = (q.st == ST_DONE) ? q.pa : '0;
        flt_vaddr       = q.va;
        flt_not_present = q.np;
        flt_write       = q.wr;
        flt_user        = q.usr;
    end
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        done_valid
);
    // R12: an outstanding access holds its fields until acknowledged
    a_r12_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11: no new request accepted while memory traffic is in flight
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R13: the result is a single-cycle pulse
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R8: every writeback carries a present entry with the accessed flag set
    a_r8_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);

    // R13: result reported only after memory traffic has ended
    a_r13_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !mem_req && !req_ready);
endmodule

bind pt_walker pw_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .done_valid (done_valid)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr, dir_base;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done_valid, done_fault, flt_not_present, flt_write, flt_user;
    logic [31:0] done_paddr, flt_vaddr;

    always #10 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr),
        .flt_vaddr(flt_vaddr), .flt_not_present(flt_not_present),
        .flt_write(flt_write), .flt_user(flt_user)
    );

    typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } acc_t;

    logic [31:0] store [int unsigned];
    acc_t        exp_q [$];
    int          checks = 0;
    int          fails  = 0;
    int          lat    = 0;
    int          cycles = 0;
    bit          in_walk = 0;
    bit          finished = 0;

    localparam logic [31:0] BASE = 32'h0010_0000;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return store.exists(a) ? store[a] : 32'h0;
    endfunction

    // behavioural reference: expected accesses and result of one walk
    task automatic model(input logic [31:0] va, input logic wr, input logic usr,
                         output logic ef, output logic enp, output logic [31:0] epa);
        logic [31:0] a, e, n;
        bit leaf;
        ef = 0; enp = 0; epa = 0;
        for (int lv = 0; lv < 2; lv++) begin
            a = (lv == 0) ? BASE + {20'h0, va[31:22], 2'b00}
                          : {rd(BASE + {20'h0, va[31:22], 2'b00}) >> 12, va[21:12], 2'b00};
            if (lv == 1) a = {rd(BASE + {20'h0, va[31:22], 2'b00})[31:12], va[21:12], 2'b00};
            exp_q.push_back({1'b0, a, 32'h0});
            e = rd(a);
            if (!e[0]) begin ef = 1; enp = 1; return; end
            if ((usr && !e[2]) || (wr && !e[1])) begin ef = 1; enp = 0; return; end
            leaf = (lv == 1) || e[7];
            n = e | 32'h20 | ((leaf && wr) ? 32'h40 : 32'h0);
            if (n != e) exp_q.push_back({1'b1, a, n});
            if (leaf) begin
                epa = (lv == 1) ? {e[31:12], va[11:0]} : {e[31:22], va[21:0]};
                return;
            end
        end
    endtask

    // memory responder: checks each access against the reference order
    initial begin
        int wc;
        acc_t x;
        mem_ack = 0; mem_rdata = 0; wc = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0; wc = 0;
            end else if (mem_req && rst_n) begin
                if (wc >= lat) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R10", "unexpected access addr", mem_addr, 32'h0);
                    end else begin
                        x = exp_q.pop_front();
                        chk(mem_we == x.we, "R8", "access direction", {31'h0, mem_we}, {31'h0, x.we});
                        chk(mem_addr == x.addr, "R2", "access address", mem_addr, x.addr);
                        if (x.we) chk(mem_wdata == x.data, "R9", "writeback data", mem_wdata, x.data);
                    end
                    if (mem_we) store[mem_addr] = mem_wdata;
                    else mem_rdata = rd(mem_addr);
                    mem_ack = 1;
                end else wc++;
            end
        end
    end

    // per-clock monitor and watchdog
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (done_valid && !in_walk) chk(0, "R13", "stray result pulse", 32'h1, 32'h0);
            if (cycles > 150000 && !finished) begin
                chk(0, "R13", "watchdog expired", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", checks, fails);
                $finish;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                        input int lt, input string tag, input bit poke);
        logic ef, enp;
        logic [31:0] epa;
        int n;
        model(va, wr, usr, ef, enp, epa);
        lat = lt;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1;
        in_walk = 1;
        @(negedge clk);
        if (poke) begin
            req_vaddr = ~va; req_write = ~wr; req_user = ~usr;
            chk(req_ready == 0, "R11", "ready while busy", {31'h0, req_ready}, 32'h0);
        end else req_valid = 0;
        n = 0;
        while (!done_valid && n < 2000) begin @(negedge clk); n++; end
        req_valid = 0;
        if (!done_valid) begin
            chk(0, tag, "no result", 32'h0, 32'h1);
        end else begin
            chk(done_fault == ef, tag, "fault flag", {31'h0, done_fault}, {31'h0, ef});
            if (ef) begin
                chk(flt_not_present == enp, tag, "fault cause", {31'h0, flt_not_present}, {31'h0, enp});
                chk(flt_vaddr == va, "R7", "fault vaddr", flt_vaddr, va);
                chk(flt_write == wr && flt_user == usr, "R7", "fault type",
                    {30'h0, flt_write, flt_user}, {30'h0, wr, usr});
            end else begin
                chk(done_paddr == epa, tag, "physical address", done_paddr, epa);
            end
        end
        @(negedge clk);
        in_walk = 0;
        chk(done_valid == 0, "R13", "result pulse width", {31'h0, done_valid}, 32'h0);
        chk(exp_q.size() == 0, "R10", "missing accesses", exp_q.size(), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_vaddr = 0; req_write = 0; req_user = 0;
        dir_base = BASE;
        repeat (5) @(negedge clk);
        chk(req_ready == 1 && mem_req == 0 && done_valid == 0, "R1", "reset outputs",
            {29'h0, req_ready, mem_req, done_valid}, 32'h4);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && mem_req == 0 && done_valid == 0, "R1", "after reset",
            {29'h0, req_ready, mem_req, done_valid}, 32'h4);

        // R3 R10: flags already set, user read, no writeback
        store[32'h0010_0004] = 32'h0020_0027; store[32'h0020_000C] = 32'h0055_5027;
        walk(32'h0040_3123, 0, 1, 0, "R3", 0);
        // R8: accessed clear at both levels
        store[32'h0010_0004] = 32'h0020_0007; store[32'h0020_000C] = 32'h0055_5007;
        walk(32'h0040_3123, 0, 0, 2, "R8", 0);
        // R9: write to leaf with dirty clear, top level untouched
        walk(32'h0040_3FFC, 1, 1, 1, "R9", 0);
        // R8 R9: write with every flag clear
        store[32'h0010_0004] = 32'h0020_0007; store[32'h0020_000C] = 32'h0055_5007;
        walk(32'h0040_3004, 1, 0, 3, "R9", 0);
        // R5: absent top level
        store[32'h0010_0004] = 32'h0020_0006;
        walk(32'h0040_3123, 0, 0, 1, "R5", 0);
        // R5: absent leaf after top-level writeback
        store[32'h0010_0004] = 32'h0020_0007; store[32'h0020_000C] = 32'h0055_5026;
        walk(32'h0040_3123, 1, 1, 0, "R5", 0);
        // R6 R10: user read of supervisor page with accessed clear
        store[32'h0010_0004] = 32'h0020_0027; store[32'h0020_000C] = 32'h0055_5003;
        walk(32'h0040_3555, 0, 1, 2, "R6", 0);
        // R6: write through read-only top level
        store[32'h0010_0004] = 32'h0020_0025;
        walk(32'h0040_3555, 1, 0, 0, "R6", 0);
        // R6: absent entry takes priority over permission
        store[32'h0010_0004] = 32'h0020_0000;
        walk(32'h0040_3555, 1, 1, 1, "R6", 0);
        // R3: supervisor read of supervisor page
        store[32'h0010_0004] = 32'h0020_0027;
        walk(32'h0040_3ABC, 0, 0, 0, "R3", 0);
        // R4: 4 MB read, then write
        store[32'h0010_00C8] = 32'h0840_0087;
        walk(32'h0C81_2345, 0, 1, 1, "R4", 0);
        walk(32'h0CBF_FFFF, 1, 1, 2, "R4", 0);
        // R11: conflicting request held during a walk
        store[32'h0010_0004] = 32'h0020_0027; store[32'h0020_000C] = 32'h0055_5027;
        walk(32'h0040_3123, 0, 1, 3, "R11", 1);
        chk(req_ready == 1, "R11", "ready after walk", {31'h0, req_ready}, 32'h1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule